// File: doc/BRIEF.md
# Stack Pointer Delta Tracker

This block sits in the decode stage. It follows the implicit stack-pointer changes made by push, pop, call and return operations, so none of them needs its own add or subtract micro-operation. It holds a signed running offset between the speculative stack pointer and the architectural stack pointer. For each stack memory access it gives the displacement to fold into the address. When an operation needs the real stack-pointer value, it asks for one synchronisation micro-operation that adds the offset to the architectural register.

Each cycle the decoder presents at most one operation descriptor. The descriptor carries a kind, an operand size in bytes, and flags for an explicit stack-pointer read, an explicit stack-pointer write, and a branch with its tag. The tracker answers in the same cycle through combinational outputs and updates its offset at the clock edge. For each in-flight branch tag it saves a checkpoint of the offset. A misprediction port restores the offset from the checkpoint selected by tag.

Top module: `sp_delta_tracker`

## Requirements
- R1: After reset the offset is zero. A plain operation (kind 0) with no flags then reports a displacement of 0 and no sync request.
- R2: A push (kind 1) or call (kind 3) lowers the offset by `op_size`. Its displacement is the lowered offset, so a second 4-byte push from zero gives -8.
- R3: A pop (kind 2) or return (kind 4) reports the offset as it was before the operation as its displacement, then raises the offset by `op_size`.
- R4: An explicit stack-pointer read while the offset is nonzero raises `sync_valid` with `sync_delta` equal to the offset. The operation's own effect is then applied starting from zero.
- R5: No sync request is raised when the offset is already zero.
- R6: An explicit stack-pointer write leaves the offset at zero. It raises a sync first only when the offset was nonzero.
- R7: The offset is an 8-bit two's-complement value. If an operation would take it outside -128..127, a sync of the current offset is forced and the operation is applied from zero.
- R8: A descriptor with the branch flag saves the offset as it stands after that operation into the checkpoint slot named by `op_br_tag`. There are 4 slots.
- R9: A recovery (`rec_valid`) loads the offset from the checkpoint slot named by `rec_tag`. An operation presented in the same cycle is discarded and raises no sync.
- R10: A plain operation with no flags leaves the offset unchanged and reports the current offset as its displacement. Cycles with no valid input also leave the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| op_valid | input | 1 | Descriptor present this cycle |
| op_kind | input | 3 | 0 plain, 1 push, 2 pop, 3 call, 4 return |
| op_size | input | 4 | Stack step in bytes |
| op_rd_sp | input | 1 | Operation reads the stack pointer explicitly |
| op_wr_sp | input | 1 | Operation writes the stack pointer explicitly |
| op_is_br | input | 1 | Operation is a branch; checkpoint the offset |
| op_br_tag | input | 2 | Checkpoint slot for this branch |
| rec_valid | input | 1 | Misprediction recovery request |
| rec_tag | input | 2 | Checkpoint slot to restore |
| disp_adj | output | 8 | Two's-complement displacement adjustment for this operation |
| sync_valid | output | 1 | Insert a sync micro-op before this operation |
| sync_delta | output | 8 | Two's-complement offset the sync adds to the stack pointer |

## Verification
Two pairs of functions can fall in the same cycle. The first is a forced sync together with the operation's own stack step. It is provoked by a push that also reads the stack pointer, and by pushes and pops driven past the 8-bit limit; the bench judges the sync value and the displacement rebuilt from zero. The second is a recovery arriving together with an operation that would otherwise sync. The bench judges it by seeing no sync request and then probing the restored offset through the displacement of a plain operation.

// File: rtl/sp_delta_pkg.sv
package sp_delta_pkg;
  typedef enum logic [2:0] {
    OP_PLAIN = 3'd0,
    OP_PUSH  = 3'd1,
    OP_POP   = 3'd2,
    OP_CALL  = 3'd3,
    OP_RET   = 3'd4
  } op_kind_e;
endpackage

// File: rtl/sp_delta_rst_sync.sv
module sp_delta_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sp_delta_calc.sv
module sp_delta_calc
  import sp_delta_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int SIZE_W = 4
) (
  input  logic [OFF_W-1:0]  off_cur,
  input  op_kind_e          kind,
  input  logic [SIZE_W-1:0] size,
  input  logic              rd_sp,
  input  logic              wr_sp,
  output logic              force_sync,
  output logic [OFF_W-1:0]  off_next,
  output logic [OFF_W-1:0]  disp
);
  localparam int WW = OFF_W + 1;

  logic [WW-1:0]    sz_ext;
  logic [WW-1:0]    step;
  logic [WW-1:0]    wide_sum;
  logic [OFF_W-1:0] base;
  logic [OFF_W-1:0] post;
  logic             is_dec;
  logic             is_inc;
  logic             ovf;
  logic             need_expl;

  always_comb begin
    sz_ext     = {{(WW-SIZE_W){1'b0}}, size};
    is_dec     = (kind == OP_PUSH) || (kind == OP_CALL);
    is_inc     = (kind == OP_POP)  || (kind == OP_RET);
    step       = is_dec ? (~sz_ext + 1'b1) : (is_inc ? sz_ext : '0);
    wide_sum   = {off_cur[OFF_W-1], off_cur} + step;
    ovf        = wide_sum[OFF_W] != wide_sum[OFF_W-1];
    need_expl  = (rd_sp || wr_sp) && (off_cur != '0);
    force_sync = ovf || need_expl;
    base       = force_sync ? '0 : off_cur;
    post       = base + step[OFF_W-1:0];
    off_next   = wr_sp ? '0 : post;
    disp       = is_dec ? post : base;
  end
endmodule

// File: rtl/sp_delta_ckpt.sv
module sp_delta_ckpt #(
  parameter int TAGS  = 4,
  parameter int OFF_W = 8,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [OFF_W-1:0] wr_val,
  input  logic [TAG_W-1:0] rd_tag,
  output logic [OFF_W-1:0] rd_val
);
  logic [OFF_W-1:0] slot_q [TAGS];

  for (genvar g = 0; g < TAGS; g++) begin : g_slot
    logic slot_en;
    always_comb slot_en = wr_en && (wr_tag == TAG_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q[g] <= '0;
      else if (slot_en) slot_q[g] <= wr_val;
    end
  end

  assign rd_val = slot_q[rd_tag];
endmodule

// File: rtl/sp_delta_tracker.sv
module sp_delta_tracker
  import sp_delta_pkg::*;
#(
  parameter int OFF_W  = 8,
  parameter int SIZE_W = 4,
  parameter int TAGS   = 4,
  localparam int TAG_W = $clog2(TAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [2:0]        op_kind,
  input  logic [SIZE_W-1:0] op_size,
  input  logic              op_rd_sp,
  input  logic              op_wr_sp,
  input  logic              op_is_br,
  input  logic [TAG_W-1:0]  op_br_tag,
  input  logic              rec_valid,
  input  logic [TAG_W-1:0]  rec_tag,
  output logic [OFF_W-1:0]  disp_adj,
  output logic              sync_valid,
  output logic [OFF_W-1:0]  sync_delta
);
  logic             rst_n_s;
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_d;
  logic             off_en;
  logic             force_sync;
  logic [OFF_W-1:0] off_next;
  logic [OFF_W-1:0] ckpt_val;
  logic             ckpt_wr;
  op_kind_e         kind;

  assign kind = op_kind_e'(op_kind);

  sp_delta_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  sp_delta_calc #(.OFF_W(OFF_W), .SIZE_W(SIZE_W)) u_calc (
    .off_cur(off_q), .kind(kind), .size(op_size), .rd_sp(op_rd_sp),
    .wr_sp(op_wr_sp), .force_sync(force_sync), .off_next(off_next),
    .disp(disp_adj)
  );

  assign ckpt_wr = op_valid && op_is_br && !rec_valid;

  sp_delta_ckpt #(.TAGS(TAGS), .OFF_W(OFF_W)) u_ckpt (
    .clk(clk), .rst_n(rst_n_s), .wr_en(ckpt_wr), .wr_tag(op_br_tag),
    .wr_val(off_next), .rd_tag(rec_tag), .rd_val(ckpt_val)
  );

  assign sync_valid = op_valid && !rec_valid && force_sync;
  assign sync_delta = off_q;

  always_comb begin
    off_en = rec_valid || op_valid;
    off_d  = rec_valid ? ckpt_val : off_next;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    off_q <= '0;
    else if (off_en) off_q <= off_d;
  end

  // A sync request never carries a zero offset.
  assert_sync_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    sync_valid |-> (sync_delta != '0));

  // A recovery squashes any operation in the same cycle.
  assert_recover_squash_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    rec_valid |-> !sync_valid);

  // A push or call without sync steps the offset down by its size.
  assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_valid && !rec_valid && !sync_valid && !op_wr_sp &&
     (kind == OP_PUSH || kind == OP_CALL))
    |=> (off_q == $past(off_q) - OFF_W'($past(op_size))));

  // A sync on a plain operation leaves the offset at zero.
  assert_sync_clears_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (sync_valid && kind == OP_PLAIN) |=> (off_q == '0));

  // With no input the offset holds.
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!op_valid && !rec_valid) |=> $stable(off_q));
endmodule

// File: tb/sp_delta_tracker_tb.sv
module sp_delta_tracker_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid, op_rd_sp, op_wr_sp, op_is_br, rec_valid;
  logic [2:0] op_kind;
  logic [3:0] op_size;
  logic [1:0] op_br_tag, rec_tag;
  logic [7:0] disp_adj, sync_delta;
  logic       sync_valid;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sp_delta_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
    .op_size(op_size), .op_rd_sp(op_rd_sp), .op_wr_sp(op_wr_sp),
    .op_is_br(op_is_br), .op_br_tag(op_br_tag), .rec_valid(rec_valid),
    .rec_tag(rec_tag), .disp_adj(disp_adj), .sync_valid(sync_valid),
    .sync_delta(sync_delta)
  );

  // Drive one cycle's inputs at the falling edge and settle before sampling.
  task automatic drive(input logic v, input logic [2:0] k, input logic [3:0] s,
                       input logic rd, input logic wr, input logic br,
                       input logic [1:0] bt, input logic rv, input logic [1:0] rt);
    @(negedge clk);
    op_valid = v; op_kind = k; op_size = s; op_rd_sp = rd; op_wr_sp = wr;
    op_is_br = br; op_br_tag = bt; rec_valid = rv; rec_tag = rt;
    #3;
  endtask

  task automatic expect_out(input string req, input logic sv,
                            input int sd, input int dp);
    n_chk++;
    if (sync_valid !== sv || (sv && $signed(sync_delta) != sd) ||
        $signed(disp_adj) != dp) begin
      n_fail++;
      $display("FAIL %s: sync=%0b delta=%0d disp=%0d, expected sync=%0b delta=%0d disp=%0d",
               req, sync_valid, $signed(sync_delta), $signed(disp_adj), sv, sd, dp);
    end
  endtask

  // Read the offset through the displacement of a plain operation.
  task automatic probe(input string req, input int exp_off);
    drive(1, 3'd0, 4'd0, 0, 0, 0, 2'd0, 0, 2'd0);
    expect_out(req, 1'b0, 0, exp_off);
  endtask

  task automatic clear_off(input int cur);
    drive(1, 3'd0, 4'd0, 0, 1, 0, 2'd0, 0, 2'd0);
    expect_out("R6", cur != 0, cur, 0);
  endtask

  task automatic t_reset;
    probe("R1", 0);
    drive(0, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0);
    probe("R10", 0);
  endtask

  task automatic t_push_sync;
    drive(1, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -4);
    drive(1, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -8);
    drive(1, 3'd0, 4'd0, 1, 0, 0, 2'd0, 0, 2'd0); expect_out("R4", 1, -8, 0);
    probe("R4", 0);
  endtask

  task automatic t_pop_ret;
    drive(1, 3'd1, 4'd2, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -2);
    drive(1, 3'd3, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -6);
    drive(1, 3'd4, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R3", 0, 0, -6);
    drive(1, 3'd2, 4'd2, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R3", 0, 0, -2);
    probe("R3", 0);
  endtask

  task automatic t_zero_and_write;
    drive(1, 3'd0, 4'd0, 1, 0, 0, 2'd0, 0, 2'd0); expect_out("R5", 0, 0, 0);
    drive(1, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -4);
    drive(1, 3'd1, 4'd4, 1, 0, 0, 2'd0, 0, 2'd0); expect_out("R4", 1, -4, -4);
    probe("R4", -4);
    clear_off(-4);
    probe("R6", 0);
    clear_off(0);
    probe("R6", 0);
  endtask

  task automatic t_overflow;
    for (int i = 1; i <= 16; i++) begin
      drive(1, 3'd1, 4'd8, 0, 0, 0, 2'd0, 0, 2'd0);
      expect_out("R7", 0, 0, -8 * i);
    end
    drive(1, 3'd1, 4'd8, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R7", 1, -128, -8);
    probe("R7", -8);
    clear_off(-8);
    for (int i = 0; i < 15; i++) begin
      drive(1, 3'd2, 4'd8, 0, 0, 0, 2'd0, 0, 2'd0);
      expect_out("R7", 0, 0, 8 * i);
    end
    drive(1, 3'd2, 4'd8, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R7", 1, 120, 0);
    probe("R7", 8);
    clear_off(8);
  endtask

  task automatic t_recover;
    drive(1, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -4);
    drive(1, 3'd0, 4'd0, 0, 0, 1, 2'd2, 0, 2'd0); expect_out("R8", 0, 0, -4);
    drive(1, 3'd3, 4'd4, 0, 0, 1, 2'd1, 0, 2'd0); expect_out("R8", 0, 0, -8);
    drive(1, 3'd1, 4'd4, 0, 0, 0, 2'd0, 0, 2'd0); expect_out("R2", 0, 0, -12);
    drive(1, 3'd0, 4'd0, 1, 0, 0, 2'd0, 1, 2'd2);
    n_chk++;
    if (sync_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R9: sync=%0b, expected sync=0", sync_valid);
    end
    probe("R9", -4);
    drive(0, 3'd0, 4'd0, 0, 0, 0, 2'd0, 1, 2'd1);
    probe("R9", -8);
    drive(0, 3'd0, 4'd0, 0, 0, 0, 2'd0, 1, 2'd2);
    probe("R8", -4);
    clear_off(-4);
  endtask

  initial begin
    rst_n = 1'b0;
    op_valid = 0; op_kind = 0; op_size = 0; op_rd_sp = 0; op_wr_sp = 0;
    op_is_br = 0; op_br_tag = 0; rec_valid = 0; rec_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push_sync();
    t_pop_ret();
    t_zero_and_write();
    t_overflow();
    t_recover();
    drive(0, 3'd0, 4'd0, 0, 0, 0, 2'd0, 0, 2'd0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule